// File: doc/BRIEF.md
# Prioritized Event-to-Host Interrupt Controller

This block gathers up to 64 single-bit system event inputs and delivers them to 10 host interrupt outputs. A rising edge on an event input sets a sticky status bit. Software clears the bit by writing a one to it. An event takes part in arbitration only while its own enable bit is set. Routing has two levels. A per-event table assigns each event to one of 10 channels. A per-channel table assigns each channel to one host. Any table entry that names a channel or host that does not exist takes that route out of use.

For every host, fixed priority selects one winner from the enabled pending events routed to it. A lower channel number beats a higher one. Within a channel, a lower event number wins. The winner's number can be read from a per-host register. Each host output comes in two forms. The level form is gated by a host enable. The pulse form is a single-cycle strobe that fires each time the level form rises. Of the ten hosts, two typically feed the local cores, one feeds a peer subsystem and seven feed external interrupt controllers. The block itself treats all ten alike.

All registers sit behind a single-cycle write port. Reads are combinational from a word address.

Top module: `evt_host_intc`

## Requirements
- R1: On every clock edge where an event input is 1 and was 0 at the previous edge, the event's status bit is set. The bit then stays set, even after the input falls, until software clears it. An input that stays high after a clear does not set the bit again.
- R2: Status words are at word addresses 0x04 (events 0..31) and 0x05 (events 32..63), with bit n holding event 32*word+n. Writing a 1 to a bit clears it. Writing a 0 leaves the bit unchanged.
- R3: Event enables are at word addresses 0x00 and 0x01, with the same bit layout as the status words. A status bit whose enable is 0 still latches but takes no part in routing. Setting the enable later makes an already latched bit take part.
- R4: Each event's channel is a 4-bit field. Event e uses word 0x10+e/8, bits 4*(e%8)+3 down to 4*(e%8). Values 0..9 select a channel. A value of 10 or more removes the event from every host.
- R5: Each channel's host is a 4-bit field. Channel c uses word 0x20+c/8, bits 4*(c%8)+3 down to 4*(c%8). Values 0..9 select a host. A value of 10 or more removes the channel from every host.
- R6: Among enabled pending events on the same channel, the lowest event number wins.
- R7: Among channels routed to the same host that hold a pending event, the lowest channel number wins, whatever the event numbers are.
- R8: Reading word 0x30+h returns the winning event number for host h in the low bits, with bit 31 clear. It returns 0x80000000 when host h has no candidate. The host enable does not affect this value.
- R9: The host enable word is at 0x08, with bit h for host h. host_level[h] is 1 exactly when host h has a candidate and its enable bit is set. It updates one clock edge after the status or configuration change that causes it.
- R10: host_pulse[h] is high for exactly the one cycle in which host_level[h] goes from 0 to 1. It does not fire when the level falls or while the level stays high.
- R11: After reset, all status bits, event enables and host enables are 0. Every mapping field is 15. Every host index word reads 0x80000000. Both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVT | System event inputs, edge-detected |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Word address for reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| host_level | output | NUM_HOST | Level-form host interrupts |
| host_pulse | output | NUM_HOST | One-cycle pulse-form host interrupts |

## Verification
The hardest case is a host with several candidates arriving on different channels, where the higher-priority channel carries the larger event number. This is the case that tells channel-first arbitration apart from a flat lowest-event search. The stimulus programs both mapping tables so that event 50 sits on channel 1 and event 2 sits on channel 6, with both channels on host 0. It fires event 2 first and then event 50, and expects the reported winner to switch to 50.

A second awkward case is an event input held high across a software clear. The bench asserts the input, clears the status while the input stays high, and confirms that the bit does not come back until a fresh rising edge arrives.

// File: rtl/evt_host_intc.sv
module evt_host_intc #(
  parameter int NUM_EVT  = 64,
  parameter int NUM_CH   = 10,
  parameter int NUM_HOST = 10,
  parameter int AW       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_in,
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data,
  output logic [NUM_HOST-1:0] host_level,
  output logic [NUM_HOST-1:0] host_pulse
);

  localparam int EW         = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int EN_BASE    = 'h00;
  localparam int ST_BASE    = 'h04;
  localparam int HEN_ADDR   = 'h08;
  localparam int CHMAP_BASE = 'h10;
  localparam int HMAP_BASE  = 'h20;
  localparam int IDX_BASE   = 'h30;

  logic [NUM_EVT-1:0]  evt_q, status, evt_en, rise, clr, pend;
  logic [3:0]          ch_map   [NUM_EVT];
  logic [3:0]          host_map [NUM_CH];
  logic [NUM_HOST-1:0] host_en, host_hit, lvl_nxt;
  logic [NUM_CH-1:0]   ch_hit;
  logic [EW-1:0]       ch_win   [NUM_CH];
  logic [EW-1:0]       host_win [NUM_HOST];

  assign rise    = evt_in & ~evt_q;
  assign pend    = status & evt_en;
  assign lvl_nxt = host_hit & host_en;

  always_comb begin
    for (int e = 0; e < NUM_EVT; e++)
      clr[e] = wr_en && (int'(addr) == ST_BASE + e / 32) && wr_data[e % 32];
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ch_hit[c] = 1'b0;
      ch_win[c] = '0;
      for (int e = NUM_EVT - 1; e >= 0; e--)
        if (pend[e] && ch_map[e] == 4'(c)) begin
          ch_hit[c] = 1'b1;
          ch_win[c] = EW'(e);
        end
    end
  end

  always_comb begin
    for (int h = 0; h < NUM_HOST; h++) begin
      host_hit[h] = 1'b0;
      host_win[h] = '0;
      for (int c = NUM_CH - 1; c >= 0; c--)
        if (ch_hit[c] && host_map[c] == 4'(h)) begin
          host_hit[h] = 1'b1;
          host_win[h] = ch_win[c];
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q      <= '0;
      status     <= '0;
      evt_en     <= '0;
      host_en    <= '0;
      host_level <= '0;
      host_pulse <= '0;
      for (int e = 0; e < NUM_EVT; e++) ch_map[e] <= 4'hF;
      for (int c = 0; c < NUM_CH; c++) host_map[c] <= 4'hF;
    end else begin
      evt_q      <= evt_in;
      status     <= (status & ~clr) | rise;
      host_level <= lvl_nxt;
      host_pulse <= lvl_nxt & ~host_level;
      if (wr_en) begin
        for (int e = 0; e < NUM_EVT; e++) begin
          if (int'(addr) == EN_BASE + e / 32) evt_en[e] <= wr_data[e % 32];
          if (int'(addr) == CHMAP_BASE + e / 8) ch_map[e] <= wr_data[4*(e%8) +: 4];
        end
        for (int c = 0; c < NUM_CH; c++)
          if (int'(addr) == HMAP_BASE + c / 8) host_map[c] <= wr_data[4*(c%8) +: 4];
        if (int'(addr) == HEN_ADDR) host_en <= wr_data[NUM_HOST-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (int'(addr) == EN_BASE + e / 32) rd_data[e % 32] = evt_en[e];
      if (int'(addr) == ST_BASE + e / 32) rd_data[e % 32] = status[e];
      if (int'(addr) == CHMAP_BASE + e / 8) rd_data[4*(e%8) +: 4] = ch_map[e];
    end
    for (int c = 0; c < NUM_CH; c++)
      if (int'(addr) == HMAP_BASE + c / 8) rd_data[4*(c%8) +: 4] = host_map[c];
    if (int'(addr) == HEN_ADDR) rd_data[NUM_HOST-1:0] = host_en;
    for (int h = 0; h < NUM_HOST; h++)
      if (int'(addr) == IDX_BASE + h)
        rd_data = host_hit[h] ? 32'(host_win[h]) : 32'h8000_0000;
  end

  p_rise_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(rise) & ~status) == '0));

  p_status_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((($past(status) & ~$past(clr)) & ~status) == '0));

  p_level_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((host_level & ~$past(host_en)) == '0));

  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((host_pulse & $past(host_pulse)) == '0));

  p_pulse_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (host_pulse == (host_level & ~$past(host_level))));

endmodule

// File: tb/evt_host_intc_test.sv
module evt_host_intc_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NONE = 32'h8000_0000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] evt_in = '0;
  logic        wr_en = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [9:0]  host_level, host_pulse;
  int checks = 0, errors = 0;

  evt_host_intc uut (.clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .host_level(host_level), .host_pulse(host_pulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); addr = 8'(a); wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); addr = 8'(a); #1 d = rd_data;
  endtask

  task automatic set_ch(int e, int c);
    logic [31:0] w;
    rd('h10 + e/8, w); w[4*(e%8) +: 4] = 4'(c); wr('h10 + e/8, w);
  endtask

  task automatic set_hm(int c, int h);
    logic [31:0] w;
    rd('h20 + c/8, w); w[4*(c%8) +: 4] = 4'(h); wr('h20 + c/8, w);
  endtask

  task automatic fire(int e);
    @(negedge clk); evt_in[e] = 1;
    @(negedge clk); evt_in[e] = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int h = 0; h < 10; h++) begin rd('h30 + h, d); chk("R11 idx none", d, NONE); end
    rd('h04, d); chk("R11 status0", d, 0);
    rd('h05, d); chk("R11 status1", d, 0);
    rd('h10, d); chk("R11 chmap", d, 32'hFFFF_FFFF);
    rd('h20, d); chk("R11 hmap", d, 32'hFFFF_FFFF);
    chk("R11 level", 32'(host_level), 0);
    chk("R11 pulse", 32'(host_pulse), 0);
  endtask

  task automatic t_route;
    logic [31:0] d;
    set_ch(5, 2); set_hm(2, 3);
    wr('h00, 32'h20); wr('h08, 32'h8);
    fire(5);
    chk("R9 level not yet", 32'(host_level), 0);
    @(negedge clk);
    chk("R9 level up", 32'(host_level), 32'h8);
    chk("R10 pulse up", 32'(host_pulse), 32'h8);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(host_pulse), 0);
    chk("R9 level held", 32'(host_level), 32'h8);
    rd('h04, d); chk("R1 status latched", d, 32'h20);
    rd('h33, d); chk("R8 idx host3", d, 5);
    rd('h30, d); chk("R8 idx host0 none", d, NONE);
    wr('h04, 32'h20);
    @(negedge clk);
    chk("R9 level fall", 32'(host_level), 0);
    chk("R10 no pulse on fall", 32'(host_pulse), 0);
    rd('h04, d); chk("R2 cleared", d, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    set_ch(6, 2);
    fire(6);
    wr('h04, ~32'h40);
    rd('h04, d); chk("R2 write0 keeps", d, 32'h40);
    rd('h33, d); chk("R3 disabled ignored", d, NONE);
    chk("R3 level off", 32'(host_level), 0);
    wr('h00, 32'h60);
    rd('h33, d); chk("R3 late enable", d, 6);
    wr('h04, 32'h40);
  endtask

  task automatic t_evt_prio;
    logic [31:0] d;
    set_ch(40, 2); set_ch(9, 2);
    wr('h00, 32'h220); wr('h01, 32'h100);
    fire(40); fire(9);
    rd('h33, d); chk("R6 lower event wins", d, 9);
    wr('h04, 32'h200);
    rd('h33, d); chk("R6 next event", d, 40);
    wr('h05, 32'h100);
  endtask

  task automatic t_ch_prio;
    logic [31:0] d;
    set_ch(50, 1); set_ch(2, 6); set_hm(1, 0); set_hm(6, 0);
    wr('h00, 32'h4); wr('h01, 32'h40000);
    fire(2);
    rd('h30, d); chk("R7 single candidate", d, 2);
    fire(50);
    rd('h30, d); chk("R7 lower channel wins", d, 50);
    wr('h05, 32'h40000);
    rd('h30, d); chk("R7 back to ch6", d, 2);
    @(negedge clk); @(negedge clk);
    chk("R9 host0 disabled level", 32'(host_level), 0);
    wr('h08, 32'h9);
    @(negedge clk);
    chk("R9 enable raises level", 32'(host_level), 32'h1);
    chk("R10 pulse on enable", 32'(host_pulse), 32'h1);
    wr('h04, 32'h4);
  endtask

  task automatic t_maps;
    logic [31:0] d;
    set_ch(2, 12);
    fire(2);
    rd('h30, d); chk("R4 chmap 12 disables", d, NONE);
    set_ch(2, 6); set_hm(6, 11);
    rd('h30, d); chk("R5 hmap 11 disables", d, NONE);
    set_ch(2, 9); set_hm(9, 0);
    rd('h30, d); chk("R4 channel 9 valid", d, 2);
    wr('h04, 32'h4);
  endtask

  task automatic t_sticky;
    logic [31:0] d;
    @(negedge clk); evt_in[2] = 1;
    @(negedge clk); @(negedge clk);
    rd('h04, d); chk("R1 held latch", d, 32'h4);
    wr('h04, 32'h4);
    rd('h04, d); chk("R1 no relatch while high", d, 0);
    evt_in[2] = 0;
    rd('h04, d); chk("R1 after fall", d, 0);
    fire(2);
    rd('h04, d); chk("R1 new edge latches", d, 32'h4);
    wr('h04, 32'h4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_route;
    t_enable;
    t_evt_prio;
    t_ch_prio;
    t_maps;
    t_sticky;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule